// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block sits on the fetch side of a processor and turns each fetch request into a physical address. It handles two kinds of request. A fetch PC with its lowest bit set belongs to privileged code. Such a fetch skips translation entirely: the PC itself becomes the physical address. Every other fetch uses the page number returned by an external translation buffer. The block joins that page number with the page offset of the PC, then classifies the result by its top address bits.

An address in uncached space is flagged and its reserved upper field is cleared. Instruction fetch from uncached space is always refused, because reading a device register may have side effects. The internal-register window inside uncached space is not implemented, and a fetch that lands there gets its own fault code. The translation buffer's storage and its refill on a miss are handled elsewhere.

All results are registered, so they appear one clock after the request.

Top module: `ifetch_xlate`

## Requirements
- R1: After reset and on any cycle that follows a cycle with `valid_i` low, `valid_o`, `phys_o`, `uncached_o` and `hit_o` are 0, `fault_o` is 0 (none) and `paddr_o` is 0.
- R2: All outputs of a request appear on the clock edge that captures it, and `valid_o` is high exactly one cycle after `valid_i` was high. Back-to-back requests each produce their own result on consecutive cycles.
- R3: A request whose `pc_i[0]` is 1 bypasses translation. `paddr_o` is `pc_i[43:0]` with bits 1:0 forced to 0, `phys_o`=1, `hit_o`=1 and `fault_o`=0, whatever `tlb_hit_i` and `tlb_ppn_i` carry.
- R4: A request with `pc_i[0]`=0 and `tlb_hit_i`=1 whose composed address `{tlb_ppn_i, pc_i[12:0]}` has bit 43 clear gives that address on `paddr_o`, with `hit_o`=1, `phys_o`=0, `uncached_o`=0 and `fault_o`=0.
- R5: A request with `pc_i[0]`=0 and `tlb_hit_i`=0 gives `fault_o`=1 (miss), `paddr_o`=0 and `hit_o`=0.
- R6: A hit whose composed address has bit 43 set, and does not have bits 42:32 all ones, gives `uncached_o`=1 and `fault_o`=2 (uncached fetch). `paddr_o` is the composed address with bits 42:35 cleared and bit 43 kept.
- R7: A hit whose composed address has bit 43 set and bits 42:32 all ones gives `fault_o`=3 (unimplemented space), `uncached_o`=0 and `paddr_o`=0.
- R8: A bypass request never reports uncached or a fault, even when its address bit 43 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Fetch request present this cycle |
| pc_i | input | 64 | Fetch PC / virtual address |
| tlb_hit_i | input | 1 | Translation buffer hit for `pc_i` |
| tlb_ppn_i | input | 31 | Physical page number from the translation buffer |
| valid_o | output | 1 | Result present |
| paddr_o | output | 44 | Physical address |
| phys_o | output | 1 | Request took the privileged bypass |
| uncached_o | output | 1 | Address lies in uncached space |
| hit_o | output | 1 | Translation available (bypass or buffer hit) |
| fault_o | output | 2 | 0 none, 1 miss, 2 uncached fetch, 3 unimplemented space |

## Verification
Every result is due exactly one clock after its request. The bench drives inputs on the falling edge, lets one rising edge capture them, and compares all outputs on the following falling edge. In the streaming test each new request is driven at the same falling edge where the previous one is checked, so results are checked on consecutive cycles. The idle check samples one falling edge after `valid_i` drops, which shows the outputs clear on the very next edge.

// File: rtl/ifetch_xlate_pkg.sv
package ifetch_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_MISS   = 2'd1,
    FLT_UNC_IF = 2'd2,
    FLT_UNIMP  = 2'd3
  } fault_e;
endpackage

// File: rtl/ifx_bypass.sv
module ifx_bypass #(
  parameter int unsigned PA_W = 44
) (
  input  logic [PA_W-1:0] pc_lo_i,
  output logic            is_byp_o,
  output logic [PA_W-1:0] byp_pa_o
);
  // low bit marks privileged PC; word-align and keep implemented width
  assign is_byp_o = pc_lo_i[0];
  assign byp_pa_o = {pc_lo_i[PA_W-1:2], 2'b00};
endmodule

// File: rtl/ifx_page_join.sv
module ifx_page_join #(
  parameter int unsigned PA_W      = 44,
  parameter int unsigned PAGE_BITS = 13,
  localparam int unsigned PPN_W    = PA_W - PAGE_BITS
) (
  input  logic [PAGE_BITS-1:0] off_i,
  input  logic [PPN_W-1:0]     ppn_i,
  output logic [PA_W-1:0]      pa_o
);
  assign pa_o = {ppn_i, off_i};
endmodule

// File: rtl/ifx_cache_class.sv
module ifx_cache_class #(
  parameter int unsigned PA_W   = 44,
  parameter int unsigned CLR_HI = 42,
  parameter int unsigned CLR_LO = 35,
  parameter int unsigned IPR_LO = 32
) (
  input  logic [PA_W-1:0] pa_i,
  output logic            uncached_o,
  output logic            unimp_o,
  output logic [PA_W-1:0] pa_clr_o
);
  localparam int unsigned MARK = PA_W - 1;

  logic [PA_W-1:0] keep_mask;

  for (genvar b = 0; b < PA_W; b++) begin : g_mask
    if (b >= CLR_LO && b <= CLR_HI) begin : g_clr
      assign keep_mask[b] = 1'b0;
    end else begin : g_keep
      assign keep_mask[b] = 1'b1;
    end
  end

  logic in_ipr;
  assign in_ipr     = &pa_i[MARK-1:IPR_LO];
  assign unimp_o    = pa_i[MARK] & in_ipr;
  assign uncached_o = pa_i[MARK] & ~in_ipr;
  assign pa_clr_o   = pa_i & keep_mask;
endmodule

// File: rtl/ifetch_xlate.sv
module ifetch_xlate
  import ifetch_xlate_pkg::*;
#(
  parameter int unsigned VA_W      = 64,
  parameter int unsigned PA_W      = 44,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned CLR_HI    = 42,
  parameter int unsigned CLR_LO    = 35,
  parameter int unsigned IPR_LO    = 32,
  localparam int unsigned PPN_W    = PA_W - PAGE_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VA_W-1:0]  pc_i,
  input  logic             tlb_hit_i,
  input  logic [PPN_W-1:0] tlb_ppn_i,
  output logic             valid_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             phys_o,
  output logic             uncached_o,
  output logic             hit_o,
  output logic [1:0]       fault_o
);
  logic            unused_pc_hi;
  logic            is_byp, unc, unimp;
  logic [PA_W-1:0] byp_pa, join_pa, clr_pa;

  assign unused_pc_hi = ^pc_i[VA_W-1:PA_W];

  ifx_bypass #(.PA_W(PA_W)) u_byp (
    .pc_lo_i (pc_i[PA_W-1:0]),
    .is_byp_o(is_byp),
    .byp_pa_o(byp_pa)
  );

  ifx_page_join #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_join (
    .off_i(pc_i[PAGE_BITS-1:0]),
    .ppn_i(tlb_ppn_i),
    .pa_o (join_pa)
  );

  ifx_cache_class #(.PA_W(PA_W), .CLR_HI(CLR_HI), .CLR_LO(CLR_LO),
                    .IPR_LO(IPR_LO)) u_cls (
    .pa_i      (join_pa),
    .uncached_o(unc),
    .unimp_o   (unimp),
    .pa_clr_o  (clr_pa)
  );

  logic            n_phys, n_unc, n_hit;
  logic [PA_W-1:0] n_pa;
  fault_e          n_flt;

  always_comb begin
    n_phys = 1'b0;
    n_unc  = 1'b0;
    n_hit  = 1'b0;
    n_pa   = '0;
    n_flt  = FLT_NONE;
    if (valid_i) begin
      if (is_byp) begin
        n_phys = 1'b1;
        n_hit  = 1'b1;
        n_pa   = byp_pa;
      end else if (!tlb_hit_i) begin
        n_flt = FLT_MISS;
      end else begin
        n_hit = 1'b1;
        if (unimp) begin
          n_flt = FLT_UNIMP;
        end else if (unc) begin
          // fetch from device space is refused
          n_unc = 1'b1;
          n_pa  = clr_pa;
          n_flt = FLT_UNC_IF;
        end else begin
          n_pa = join_pa;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      paddr_o    <= '0;
      phys_o     <= 1'b0;
      uncached_o <= 1'b0;
      hit_o      <= 1'b0;
      fault_o    <= FLT_NONE;
    end else begin
      valid_o    <= valid_i;
      paddr_o    <= n_pa;
      phys_o     <= n_phys;
      uncached_o <= n_unc;
      hit_o      <= n_hit;
      fault_o    <= n_flt;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (fault_o == FLT_NONE && paddr_o == '0 && !hit_o && !phys_o));
  a_r8_bypass_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && phys_o) |-> (fault_o == FLT_NONE && !uncached_o && hit_o));
  a_r5_miss_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o == FLT_MISS) |-> (paddr_o == '0 && !hit_o));
  a_r6_unc_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncached_o |-> (fault_o == FLT_UNC_IF && paddr_o[CLR_HI:CLR_LO] == '0
                    && paddr_o[PA_W-1]));
  a_r7_unimp_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o == FLT_UNIMP) |-> (!uncached_o && paddr_o == '0));
  a_r3_bypass_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_o |-> (paddr_o[1:0] == 2'b00));
endmodule

// File: tb/ifetch_xlate_tb_top.sv
module ifetch_xlate_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] pc_i = '0;
  logic        tlb_hit_i = 1'b0;
  logic [30:0] tlb_ppn_i = '0;
  logic        valid_o, phys_o, uncached_o, hit_o;
  logic [43:0] paddr_o;
  logic [1:0]  fault_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  ifetch_xlate dut_i (
    .clk_i, .rst_ni, .valid_i, .pc_i, .tlb_hit_i, .tlb_ppn_i,
    .valid_o, .paddr_o, .phys_o, .uncached_o, .hit_o, .fault_o
  );

  // expected {valid, pa, fault, unc, phys, hit} from the requirements
  function automatic logic [49:0] model(logic v, logic [63:0] pc, logic h,
                                        logic [30:0] ppn);
    logic [43:0] pa;
    if (!v) return '0;
    if (pc[0]) return {1'b1, pc[43:2], 2'b00, 2'd0, 1'b0, 1'b1, 1'b1};
    if (!h) return {1'b1, 44'h0, 2'd1, 1'b0, 1'b0, 1'b0};
    pa = {ppn, pc[12:0]};
    if (!pa[43]) return {1'b1, pa, 2'd0, 1'b0, 1'b0, 1'b1};
    if (&pa[42:32]) return {1'b1, 44'h0, 2'd3, 1'b0, 1'b0, 1'b1};
    pa[42:35] = '0;
    return {1'b1, pa, 2'd2, 1'b1, 1'b0, 1'b1};
  endfunction

  task automatic check(string req, logic [49:0] exp);
    logic [49:0] act;
    act = {valid_o, paddr_o, fault_o, uncached_o, phys_o, hit_o};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual v=%b pa=%h flt=%0d unc=%b phys=%b hit=%b expected v=%b pa=%h flt=%0d unc=%b phys=%b hit=%b",
               req, act[49], act[48:5], act[4:3], act[2], act[1], act[0],
               exp[49], exp[48:5], exp[4:3], exp[2], exp[1], exp[0]);
    end
  endtask

  // one request, result checked one cycle later
  task automatic one_req(string req, logic [63:0] pc, logic h, logic [30:0] ppn);
    @(negedge clk_i);
    valid_i = 1'b1; pc_i = pc; tlb_hit_i = h; tlb_ppn_i = ppn;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(req, model(1'b1, pc, h, ppn));
  endtask

  task automatic t_reset();
    check("R1 reset", '0);
  endtask

  task automatic t_bypass();
    one_req("R3 bypass", 64'h0000_0123_4567_89AB, 1'b0, 31'h0);
    one_req("R3 bypass ignores tlb", 64'h0000_0ABC_DEF0_1237, 1'b1, 31'h7FFF_FFFF);
    one_req("R8 bypass bit43", 64'hFFFF_F800_0000_1001, 1'b0, 31'h0);
    one_req("R8 bypass ipr window", 64'h0000_0FFF_0000_0005, 1'b1, 31'h0);
  endtask

  task automatic t_hit();
    one_req("R4 hit", 64'h0000_0000_0000_1ABC, 1'b1, 31'h0012_3456);
    one_req("R4 hit max cached ppn", 64'hDEAD_0000_0000_1FFE, 1'b1, 31'h3FFF_FFFF);
  endtask

  task automatic t_miss();
    one_req("R5 miss", 64'h0000_0000_0040_2000, 1'b0, 31'h0055_5555);
  endtask

  task automatic t_uncached();
    one_req("R6 uncached", 64'h0000_0000_0000_0F00, 1'b1, 31'h4AB0_1234);
    one_req("R6 ipr boundary", 64'h0000_0000_0000_0010, 1'b1, 31'h7FF0_0000);
    one_req("R7 unimp", 64'h0000_0000_0000_0ABC, 1'b1, 31'h7FF8_0ABC);
  endtask

  task automatic t_idle();
    one_req("R4 pre-idle", 64'h0000_0000_0000_0004, 1'b1, 31'h0000_0001);
    @(negedge clk_i);
    check("R1 idle after request", '0);
  endtask

  task automatic t_stream();
    logic [63:0] pcs [3] = '{64'h0000_0000_0000_0203, 64'h0000_0000_0000_0400,
                             64'h0000_0000_0000_0808};
    logic        hs  [3] = '{1'b0, 1'b0, 1'b1};
    logic [30:0] ps  [3] = '{31'h0, 31'h1, 31'h4000_0002};
    @(negedge clk_i);
    for (int i = 0; i < 3; i++) begin
      valid_i = 1'b1; pc_i = pcs[i]; tlb_hit_i = hs[i]; tlb_ppn_i = ps[i];
      @(negedge clk_i);
      check($sformatf("R2 stream %0d", i), model(1'b1, pcs[i], hs[i], ps[i]));
    end
    valid_i = 1'b0;
    @(negedge clk_i);
    check("R2 stream drain", '0);
  endtask

  initial begin
    #20000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_bypass();
    t_hit();
    t_miss();
    t_uncached();
    t_idle();
    t_stream();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule